// File: doc/BRIEF.md
# Two-Level First-Come-First-Served Bus Arbiter

A synchronous central arbiter for a fixed set of module slots. Each slot drives two request lines, one at high priority and one at low priority, and may hold both at once. The arbiter remembers the order in which requests arrived. It hands the bus to the longest-waiting high-priority request. A low-priority request is served only while no high-priority request is present on any slot. The slot's index gives it no preference, except to break a tie between requests that arrived in the same cycle. At most one slot holds the grant at a time, and an any-grant flag reports that some slot holds it.

An enable input and an inhibit input, the latter driven by an external reset monitor, gate the issue of new grants. Neither one takes away a grant that is already held: the owning slot keeps the bus until it drops all of its requests. The preempt output tells the current owner that others are waiting. In priority mode it is raised when a grant is held and some high-priority request is not the one being served. In count mode it is raised whenever two or more slots request, and a slot holding both lines counts as one. The reset monitor can also force preempt high. All requests are taken to be synchronous to the clock already.

Top module: `duo_age_arbiter`

## Requirements
- R1: While reset is asserted and on the first cycle after it, grant is all zeros and any_grant is low.
- R2: Among the requests pending at one level, the slot whose request has been asserted the longest receives the next grant. Requests that arrived in the same cycle are ordered by lowest slot index.
- R3: A low-priority request is granted only in a cycle in which no req_hi bit is set on any slot.
- R4: At most one bit of grant is set in any cycle.
- R5: A new grant is issued only while enable is 1 and inhibit is 0. A grant already held stays unchanged while its slot keeps either request line asserted, whatever enable and inhibit do.
- R6: any_grant is 1 exactly when some grant bit is 1.
- R7: A request that is dropped before it is granted leaves the order, and the relative order of the remaining requests is unchanged.
- R8: With prio_mode = 1, preempt is 1 when a grant is held and some slot asserts req_hi without being the owner served at high priority.
- R9: With prio_mode = 0, preempt is 1 when two or more slots assert either request line. A slot asserting both lines counts once.
- R10: force_pe = 1 drives preempt to 1 regardless of requests and mode.
- R11: Timing. A request sampled at clock edge k can first be granted at edge k+1. A grant is cleared at the first edge at which its slot asserts no request, and no new grant is issued at that same edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| req_hi | input | N_SLOTS | High-priority request, one bit per slot |
| req_lo | input | N_SLOTS | Low-priority request, one bit per slot |
| enable | input | 1 | Permits new grants when 1 |
| inhibit | input | 1 | Reset-monitor grant block, blocks new grants when 1 |
| force_pe | input | 1 | Reset-monitor request to force preempt high |
| prio_mode | input | 1 | 1 selects priority preemption, 0 selects count preemption |
| grant | output | N_SLOTS | One-hot grant, bit i for slot i |
| any_grant | output | 1 | 1 while any grant bit is set |
| preempt | output | 1 | Preemption flag |

## Verification
The bench builds the arbiter at its default of 14 slots. At that width the queues run deep enough to show an old request overtaking several younger ones, a withdrawal in the middle of a long queue, and same-cycle ties between widely separated indices. A behavioural queue model follows every cycle of a long pseudo-random run, in which requests are raised and withdrawn on both levels and enable, inhibit, mode and force are toggled, while directed sequences aim at each ordering, gating and preemption corner.

// File: rtl/duo_age_arbiter.sv
module duo_age_arbiter #(
  parameter int N_SLOTS = 14
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [N_SLOTS-1:0] req_hi,
  input  logic [N_SLOTS-1:0] req_lo,
  input  logic               enable,
  input  logic               inhibit,
  input  logic               force_pe,
  input  logic               prio_mode,
  output logic [N_SLOTS-1:0] grant,
  output logic               any_grant,
  output logic               preempt
);
  localparam logic [N_SLOTS-1:0] ONE = N_SLOTS'(1);

  logic [N_SLOTS-1:0] lvl_req [2];
  logic [N_SLOTS-1:0] lvl_win [2];
  logic [1:0]         lvl_has;

  assign lvl_req[0] = req_lo;
  assign lvl_req[1] = req_hi;

  for (genvar l = 0; l < 2; l++) begin : g_lvl
    logic [N_SLOTS-1:0] seen;
    logic [N_SLOTS-1:0] pend;
    logic [N_SLOTS-1:0] rise;
    logic [N_SLOTS-1:0] head;
    logic [N_SLOTS-1:0] older [N_SLOTS];

    assign pend = lvl_req[l] & seen;
    assign rise = lvl_req[l] & ~seen;

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        seen <= '0;
        for (int i = 0; i < N_SLOTS; i++) older[i] <= '0;
      end else begin
        seen <= lvl_req[l];
        for (int i = 0; i < N_SLOTS; i++)
          for (int j = 0; j < N_SLOTS; j++)
            older[i][j] <= (i != j) && lvl_req[l][i] && lvl_req[l][j] &&
                           (rise[j] ? seen[i] : (!rise[i] && older[i][j]));
      end
    end

    always_comb begin
      for (int i = 0; i < N_SLOTS; i++) begin
        logic blocked;
        blocked = 1'b0;
        for (int j = 0; j < N_SLOTS; j++)
          if (pend[j] && older[j][i]) blocked = 1'b1;
        head[i] = pend[i] && !blocked;
      end
    end

    assign lvl_win[l] = head & (~head + ONE);
    assign lvl_has[l] = |pend;
  end

  logic [N_SLOTS-1:0] grant_q;
  logic               grant_hi_q;

  wire owner_holds = |(grant_q & (req_hi | req_lo));
  wire may_issue   = !(|grant_q) && enable && !inhibit;
  wire take_hi     = lvl_has[1];
  wire take_lo     = !take_hi && lvl_has[0] && !(|req_hi);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      grant_q    <= '0;
      grant_hi_q <= 1'b0;
    end else if (|grant_q) begin
      if (!owner_holds) grant_q <= '0;
    end else if (may_issue && take_hi) begin
      grant_q    <= lvl_win[1];
      grant_hi_q <= 1'b1;
    end else if (may_issue && take_lo) begin
      grant_q    <= lvl_win[0];
      grant_hi_q <= 1'b0;
    end
  end

  assign grant     = grant_q;
  assign any_grant = |grant_q;

  wire [N_SLOTS-1:0] served_hi = grant_hi_q ? grant_q : '0;
  wire [N_SLOTS-1:0] merged    = req_hi | req_lo;
  wire               prio_pe   = any_grant && |(req_hi & ~served_hi);
  wire               count_pe  = |(merged & (merged - ONE));

  assign preempt = force_pe || (prio_mode ? prio_pe : count_pe);

  AST_ONE_OWNER: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(grant_q)); // R4

  AST_HOLD_GRANT: assert property (@(posedge clk) disable iff (!rst_n)
    (|grant_q && owner_holds) |=> $stable(grant_q)); // R5

  AST_GATED_ISSUE: assert property (@(posedge clk) disable iff (!rst_n)
    (!(|grant_q) && (!enable || inhibit)) |=> !(|grant_q)); // R5

  AST_RELEASE_GAP: assert property (@(posedge clk) disable iff (!rst_n)
    (|grant_q && !owner_holds) |=> !(|grant_q)); // R11

  AST_LOW_BLOCKED: assert property (@(posedge clk) disable iff (!rst_n)
    (!(|grant_q) && (|req_hi)) |=> (!(|grant_q) || |(grant_q & $past(req_hi)))); // R3
endmodule

// File: tb/duo_age_arbiter_bench.sv
module duo_age_arbiter_bench;
  localparam int N = 14;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [N-1:0] req_hi = '0, req_lo = '0;
  logic enable = 1'b1, inhibit = 1'b0, force_pe = 1'b0, prio_mode = 1'b1;
  logic [N-1:0] grant;
  logic any_grant, preempt;

  always #2 clk = ~clk;

  duo_age_arbiter #(.N_SLOTS(N)) u_duo_age_arbiter (
    .clk(clk), .rst_n(rst_n), .req_hi(req_hi), .req_lo(req_lo),
    .enable(enable), .inhibit(inhibit), .force_pe(force_pe),
    .prio_mode(prio_mode), .grant(grant), .any_grant(any_grant),
    .preempt(preempt));

  int total = 0, fails = 0;

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  int qh[$], ql[$], tmp[$];
  logic [N-1:0] ph = '0, pl = '0;
  int gm = -1;
  bit gm_hi = 1'b0;

  task automatic model_step();
    int ng;
    bit nh;
    if (!rst_n) begin
      qh.delete(); ql.delete(); ph = '0; pl = '0; gm = -1; gm_hi = 1'b0;
      return;
    end
    ng = gm; nh = gm_hi;
    if (gm >= 0) begin
      if (!(req_hi[gm] || req_lo[gm])) ng = -1;
    end else if (enable && !inhibit) begin
      int ch = -1;
      foreach (qh[k]) if (ch < 0 && req_hi[qh[k]]) ch = qh[k];
      if (ch >= 0) begin ng = ch; nh = 1'b1; end
      else if (req_hi == '0) begin
        int cl = -1;
        foreach (ql[k]) if (cl < 0 && req_lo[ql[k]]) cl = ql[k];
        if (cl >= 0) begin ng = cl; nh = 1'b0; end
      end
    end
    tmp.delete();
    foreach (qh[k]) if (req_hi[qh[k]]) tmp.push_back(qh[k]);
    for (int i = 0; i < N; i++) if (req_hi[i] && !ph[i]) tmp.push_back(i);
    qh = tmp;
    tmp.delete();
    foreach (ql[k]) if (req_lo[ql[k]]) tmp.push_back(ql[k]);
    for (int i = 0; i < N; i++) if (req_lo[i] && !pl[i]) tmp.push_back(i);
    ql = tmp;
    ph = req_hi; pl = req_lo;
    gm = ng; gm_hi = nh;
  endtask

  function automatic bit model_pe();
    int cnt = 0;
    bit waiting = 1'b0;
    if (force_pe) return 1'b1;
    if (prio_mode) begin
      for (int i = 0; i < N; i++) if (req_hi[i] && !(gm_hi && gm == i)) waiting = 1'b1;
      return (gm >= 0) && waiting;
    end
    for (int i = 0; i < N; i++) if (req_hi[i] || req_lo[i]) cnt++;
    return cnt >= 2;
  endfunction

  always begin
    @(posedge clk);
    model_step();
    #1;
    if (rst_n) begin
      logic [N-1:0] eg;
      eg = (gm >= 0) ? (N'(1) << gm) : '0;
      chk("R2 grant vs model", 32'(grant), 32'(eg));
      chk("R6 any_grant vs model", 32'(any_grant), 32'(gm >= 0));
      chk("R8 preempt vs model", 32'(preempt), 32'(model_pe()));
    end
  end

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    step(3);
    chk("R1 grant in reset", 32'(grant), 0);
    chk("R1 any_grant in reset", 32'(any_grant), 0);
    rst_n = 1'b1;
    step(1);
    chk("R1 grant after reset", 32'(grant), 0);
    chk("R1 any_grant after reset", 32'(any_grant), 0);

    req_hi[9] = 1; step(1); req_hi[2] = 1; step(1); req_hi[5] = 1; step(1);
    chk("R2 oldest first", 32'(grant), 32'(1 << 9));
    chk("R6 any_grant set", 32'(any_grant), 1);
    req_hi[9] = 0; step(1);
    chk("R11 gap after release", 32'(grant), 0);
    step(1);
    chk("R2 second oldest", 32'(grant), 32'(1 << 2));
    req_hi[2] = 0; step(2);
    chk("R2 third", 32'(grant), 32'(1 << 5));
    req_hi[5] = 0; step(2);

    req_hi[11] = 1; req_hi[4] = 1; step(1);
    chk("R11 not granted one edge after request", 32'(grant), 0);
    step(1);
    chk("R2 tie lowest index", 32'(grant), 32'(1 << 4));
    req_hi[4] = 0; step(2);
    chk("R2 tie partner", 32'(grant), 32'(1 << 11));
    req_hi[11] = 0; step(2);

    req_hi[0] = 1; step(3);
    req_hi[7] = 1; step(1); req_hi[3] = 1; step(1); req_hi[12] = 1; step(1);
    req_hi[3] = 0; step(1);
    req_hi[0] = 0; step(2);
    chk("R7 order after withdrawal", 32'(grant), 32'(1 << 7));
    req_hi[7] = 0; step(2);
    chk("R7 remaining request", 32'(grant), 32'(1 << 12));
    req_hi[12] = 0; step(2);

    req_lo[1] = 1; step(3);
    chk("R3 low granted when no high", 32'(grant), 32'(1 << 1));
    req_lo[6] = 1; step(1); req_hi[8] = 1; step(1);
    req_lo[1] = 0; step(2);
    chk("R3 high beats older low", 32'(grant), 32'(1 << 8));
    req_hi[8] = 0; step(2);
    chk("R3 low after high gone", 32'(grant), 32'(1 << 6));
    req_lo[6] = 0; step(3);

    enable = 0; req_hi[10] = 1; step(4);
    chk("R5 no grant while disabled", 32'(grant), 0);
    enable = 1; step(2);
    chk("R5 grant after enable", 32'(grant), 32'(1 << 10));
    enable = 0; step(3);
    chk("R5 grant kept after enable drop", 32'(grant), 32'(1 << 10));
    req_hi[10] = 0; step(2);
    chk("R5 released", 32'(grant), 0);
    enable = 1; inhibit = 1; req_lo[13] = 1; step(4);
    chk("R5 no grant while inhibited", 32'(grant), 0);
    inhibit = 0; step(2);
    chk("R5 grant after inhibit", 32'(grant), 32'(1 << 13));
    req_lo[13] = 0; step(3);

    prio_mode = 1; req_hi[2] = 1; step(3);
    req_lo[3] = 1; step(1);
    chk("R8 low waiter no preempt", 32'(preempt), 0);
    req_hi[4] = 1; step(1);
    chk("R8 high waiter preempts", 32'(preempt), 1);
    req_hi = '0; req_lo = '0; step(3);
    prio_mode = 0; req_hi[5] = 1; req_lo[5] = 1; step(1);
    chk("R9 one slot both levels", 32'(preempt), 0);
    req_lo[6] = 1; step(1);
    chk("R9 two slots", 32'(preempt), 1);
    req_hi = '0; req_lo = '0; step(3);
    force_pe = 1; step(1);
    chk("R10 forced preempt", 32'(preempt), 1);
    force_pe = 0; prio_mode = 1; step(2);

    for (int cyc = 0; cyc < 3000; cyc++) begin
      @(negedge clk);
      for (int s = 0; s < N; s++) begin
        if (grant[s] && $urandom_range(3) == 0) begin
          req_hi[s] = 0; req_lo[s] = 0;
        end else begin
          if ($urandom_range(15) == 0) req_hi[s] = ~req_hi[s];
          if ($urandom_range(15) == 0) req_lo[s] = ~req_lo[s];
        end
      end
      if ($urandom_range(63) == 0) enable = ~enable;
      if ($urandom_range(99) == 0) inhibit = ~inhibit;
      if ($urandom_range(199) == 0) prio_mode = ~prio_mode;
      if ($urandom_range(49) == 0) force_pe = ~force_pe;
    end
    step(2);
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    total++; fails++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end
endmodule